// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification

This block merges the four interrupt causes of a serial port into one interrupt request line, and into an identification byte that names the most urgent cause. The four causes are receiver line errors, received data ready (a FIFO fill level or a character timeout), a transmit holding register that has emptied, and a change on the modem inputs. Each cause is gated by its own bit in an enable register. Each cause is latched inside the block, whether or not it is enabled. When its cause is disabled, the latched state stays hidden until software enables it.

The surrounding port logic supplies single-cycle event strobes for new conditions. It also supplies a receive-level input and single-cycle strobes that mark software accesses: reading the line status, reading the receive buffer, reading the modem status, writing the transmit holding register, and reading the identification byte. These accesses clear the matching latched cause. When the identification byte is read while it reports transmit-empty, that read is enough to clear the transmit-empty cause. If a more urgent cause is being reported at the time of the read, the transmit-empty cause stays latched and appears later.

Top module: `uart_irq_ident`

## Requirements
- R1: `ier_rdata[3:0]` returns the enable bits last written through `ier_wr`/`ier_wdata`, with bits 7:4 reading zero. The bit mapping is: bit 0 enables data ready (level and timeout), bit 1 enables transmit-empty, bit 2 enables line errors, bit 3 enables modem change. The reset value is zero.
- R2: `irq` is 1 exactly when at least one enabled cause is pending. It changes on the clock edge that samples the triggering input, so it is never combinational from an event input.
- R3: `iir[0]` is 0 while an enabled cause is pending and 1 when none is.
- R4: `iir[2:1]` names the highest-priority enabled pending cause: 11 line error (highest), 10 data ready, 01 transmit-empty, 00 modem change (lowest). With nothing pending, `iir[3:1]` is 000.
- R5: `iir[3]` is 1 only while data ready is the reported cause and a character timeout is latched.
- R6: `iir[7:6]` both equal `fifo_en`, and `iir[5:4]` is always 00.
- R7: The line-error cause is latched by `lsr_evt` and cleared by `rd_lsr`. When both strobes arrive in the same cycle, the cause stays set.
- R8: The data-ready cause is pending while the registered `rx_level` is 1, or while a timeout latched by `rx_tmo_evt` is held. `rd_rbr` clears the timeout latch.
- R9: The modem-change cause is latched by `msr_evt` and cleared by `rd_msr`. When both strobes arrive in the same cycle, the cause stays set.
- R10: The transmit-empty cause is latched by `thr_xfer` and cleared by `wr_thr`. When both strobes arrive in the same cycle, the cause stays set.
- R11: An `rd_iir` strobe clears transmit-empty only in the cycle in which `iir[3:0]` is 0010. If a more urgent cause is being reported, transmit-empty stays latched and is reported once the more urgent cause clears.
- R12: A disabled cause still latches, but it drives neither `irq` nor `iir`. Enabling it later makes it visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable bits to write |
| ier_rdata | output | 8 | Enable register readback |
| fifo_en | input | 1 | FIFOs enabled, mirrored in iir[7:6] |
| lsr_evt | input | 1 | Strobe: a receive error was detected |
| rx_level | input | 1 | Level: receive data ready or FIFO at trigger |
| rx_tmo_evt | input | 1 | Strobe: character timeout occurred |
| thr_xfer | input | 1 | Strobe: holding register moved into the shift register |
| msr_evt | input | 1 | Strobe: a modem input changed |
| rd_lsr | input | 1 | Strobe: line status read |
| rd_rbr | input | 1 | Strobe: receive buffer read |
| rd_msr | input | 1 | Strobe: modem status read |
| wr_thr | input | 1 | Strobe: transmit holding register written |
| rd_iir | input | 1 | Strobe: identification byte read |
| irq | output | 1 | Interrupt request |
| iir | output | 8 | Identification byte |

## Verification
The assertions assume that every event and access strobe is synchronous to `clk` and is already a single-cycle pulse. They also assume that `rd_iir` refers to the identification byte shown in that same cycle. The assertions on clearing are conditioned on the absence of a simultaneous setting event, because a set takes precedence over a clear. The stimulus drives every input just after the falling edge and holds it for exactly one cycle. Both the directed and the random phases collide set and clear strobes on purpose, so the precedence rule is exercised without breaking these assumptions.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 4;
  localparam int IDW    = $clog2(NSRC);
  // source index equals its two-bit identification code; higher wins
  localparam int ID_MSR = 0;
  localparam int ID_TXE = 1;
  localparam int ID_RXD = 2;
  localparam int ID_LSE = 3;

  function automatic logic [IDW-1:0] pick_top(input logic [NSRC-1:0] act);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (act[i]) r = IDW'(i);
    return r;
  endfunction

  function automatic logic [7:0] build_ident(input logic any, input logic [IDW-1:0] id,
                                             input logic tmo, input logic fifo);
    return {fifo, fifo, 2'b00, any & tmo & (id == IDW'(ID_RXD)), any ? id : '0, ~any};
  endfunction
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act_i,
  input  logic            tmo_i,
  input  logic            fifo_i,
  output logic            any_o,
  output logic [7:0]      ident_o
);
  logic [IDW-1:0] top_id;
  assign any_o   = |act_i;
  assign top_id  = pick_top(act_i);
  assign ident_o = build_ident(any_o, top_id, tmo_i, fifo_i);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_wr,
  input  logic [3:0] ier_wdata,
  output logic [7:0] ier_rdata,
  input  logic       fifo_en,
  input  logic       lsr_evt,
  input  logic       rx_level,
  input  logic       rx_tmo_evt,
  input  logic       thr_xfer,
  input  logic       msr_evt,
  input  logic       rd_lsr,
  input  logic       rd_rbr,
  input  logic       rd_msr,
  input  logic       wr_thr,
  input  logic       rd_iir,
  output logic       irq,
  output logic [7:0] iir
);
  logic [3:0]      ier_q;
  logic            rxlvl_q;
  logic [NSRC-1:0] set_v, clr_v, latch_v;
  logic [NSRC-1:0] pend_v, en_v, act_v;
  logic            any_act;
  // named internal events for the checker
  logic            lse_pend, tmo_pend, txe_pend, msr_pend, txe_reported;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ier_q   <= '0;
      rxlvl_q <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= ier_wdata;
      rxlvl_q <= rx_level;
    end

  assign ier_rdata    = {4'b0000, ier_q};
  assign txe_reported = (iir[3:0] == {1'b0, 2'(ID_TXE), 1'b0});

  // latch slot ID_RXD holds the character timeout
  assign set_v[ID_MSR] = msr_evt;
  assign clr_v[ID_MSR] = rd_msr;
  assign set_v[ID_TXE] = thr_xfer;
  assign clr_v[ID_TXE] = wr_thr | (rd_iir & txe_reported);
  assign set_v[ID_RXD] = rx_tmo_evt;
  assign clr_v[ID_RXD] = rd_rbr;
  assign set_v[ID_LSE] = lsr_evt;
  assign clr_v[ID_LSE] = rd_lsr;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    uart_irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .pend_o(latch_v[g])
    );
  end

  assign lse_pend = latch_v[ID_LSE];
  assign tmo_pend = latch_v[ID_RXD];
  assign txe_pend = latch_v[ID_TXE];
  assign msr_pend = latch_v[ID_MSR];

  always_comb begin
    pend_v         = latch_v;
    pend_v[ID_RXD] = latch_v[ID_RXD] | rxlvl_q;
    en_v[ID_RXD]   = ier_q[0];
    en_v[ID_TXE]   = ier_q[1];
    en_v[ID_LSE]   = ier_q[2];
    en_v[ID_MSR]   = ier_q[3];
  end

  assign act_v = pend_v & en_v;

  uart_irq_prio u_prio (
    .act_i  (act_v),
    .tmo_i  (tmo_pend),
    .fifo_i (fifo_en),
    .any_o  (any_act),
    .ident_o(iir)
  );

  assign irq = any_act;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lsr_evt,
  input logic       thr_xfer,
  input logic       msr_evt,
  input logic       rd_lsr,
  input logic       rd_msr,
  input logic       wr_thr,
  input logic       rd_iir,
  input logic [7:0] ier_rdata,
  input logic [7:0] iir,
  input logic       irq,
  input logic       lse_pend,
  input logic       txe_pend,
  input logic       msr_pend
);
  assert_lse_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !lsr_evt) |=> !lse_pend);
  assert_lse_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_evt |=> lse_pend);
  assert_msr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && !msr_evt) |=> !msr_pend);
  assert_txe_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    thr_xfer |=> txe_pend);
  assert_txe_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && iir[3:0] == 4'b0010 && !thr_xfer) |=> !txe_pend);
  assert_txe_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && txe_pend && iir[3:0] != 4'b0010 && !wr_thr) |=> txe_pend);
  assert_lse_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lse_pend && ier_rdata[2]) |-> (iir[3:0] == 4'b0110 && irq));
  assert_irq_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq != iir[0]);
endmodule

bind uart_irq_ident uart_irq_ident_chk i_chk (
  .clk(clk), .rst_n(rst_n), .lsr_evt(lsr_evt), .thr_xfer(thr_xfer), .msr_evt(msr_evt),
  .rd_lsr(rd_lsr), .rd_msr(rd_msr), .wr_thr(wr_thr), .rd_iir(rd_iir),
  .ier_rdata(ier_rdata), .iir(iir), .irq(irq),
  .lse_pend(lse_pend), .txe_pend(txe_pend), .msr_pend(msr_pend)
);

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ier_wr = 0; logic [3:0] ier_wdata = '0; logic [7:0] ier_rdata;
  logic fifo_en = 0, lsr_evt = 0, rx_level = 0, rx_tmo_evt = 0, thr_xfer = 0, msr_evt = 0;
  logic rd_lsr = 0, rd_rbr = 0, rd_msr = 0, wr_thr = 0, rd_iir = 0;
  logic irq; logic [7:0] iir;
  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (.*);

  // behavioural reference state
  bit m_lse, m_tmo, m_txe, m_msr, m_lvl;
  bit [3:0] m_ier;

  function automatic bit [7:0] model_iir();
    bit [7:0] v;
    v = {fifo_en, fifo_en, 6'b000001};
    if (m_ier[2] && m_lse) v[3:0] = 4'b0110;
    else if (m_ier[0] && (m_lvl || m_tmo)) v[3:0] = m_tmo ? 4'b1100 : 4'b0100;
    else if (m_ier[1] && m_txe) v[3:0] = 4'b0010;
    else if (m_ier[3] && m_msr) v[3:0] = 4'b0000;
    return v;
  endfunction

  always @(posedge clk) if (rst_n) begin
    bit [7:0] shown;
    shown = model_iir();
    if (rd_lsr) m_lse = 0;
    if (lsr_evt) m_lse = 1;
    if (rd_rbr) m_tmo = 0;
    if (rx_tmo_evt) m_tmo = 1;
    if (rd_msr) m_msr = 0;
    if (msr_evt) m_msr = 1;
    if (wr_thr || (rd_iir && shown[3:0] == 4'b0010)) m_txe = 0;
    if (thr_xfer) m_txe = 1;
    m_lvl = rx_level;
    if (ier_wr) m_ier = ier_wdata;
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from both edges
  always begin
    bit [7:0] e;
    @(negedge clk); #5;
    if (rst_n) begin
      e = model_iir();
      check("R2 irq", irq, !e[0]);
      check("R3 pending bit", iir[0], e[0]);
      check("R4 source code", iir[2:1], e[2:1]);
      check("R5 timeout bit", iir[3], e[3]);
      check("R6 upper bits", iir[7:4], e[7:4]);
      check("R1 enable readback", ier_rdata, {4'b0, m_ier});
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  task automatic cyc();
    @(negedge clk);
    ier_wr = 0; lsr_evt = 0; rx_tmo_evt = 0; thr_xfer = 0; msr_evt = 0;
    rd_lsr = 0; rd_rbr = 0; rd_msr = 0; wr_thr = 0; rd_iir = 0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    check("R3 reset iir", iir, 8'h01);
    check("R2 reset irq", irq, 0);
    check("R1 reset enables", ier_rdata, 0);

    ier_wr = 1; ier_wdata = 4'hF; cyc();
    check("R1 enable write", ier_rdata, 8'h0F);

    thr_xfer = 1; #2;
    check("R2 no same-cycle irq", irq, 0);
    cyc();
    check("R10 txe reported", iir, 8'h02);
    check("R2 irq raised", irq, 1);
    rd_iir = 1; cyc();
    check("R11 read clears txe", iir, 8'h01);

    thr_xfer = 1; lsr_evt = 1; cyc();
    check("R4 R7 line error on top", iir, 8'h06);
    rd_iir = 1; cyc();
    check("R11 masked txe kept", iir, 8'h06);
    rd_lsr = 1; cyc();
    check("R11 txe surfaces later", iir, 8'h02);
    wr_thr = 1; cyc();
    check("R10 write clears txe", iir, 8'h01);

    rx_level = 1; cyc(); rx_level = 0;
    check("R8 level data ready", iir, 8'h04);
    rx_tmo_evt = 1; cyc();
    check("R5 timeout flagged", iir, 8'h0C);
    rd_rbr = 1; cyc();
    check("R8 timeout cleared", iir, 8'h01);

    msr_evt = 1; cyc();
    check("R9 modem change", iir, 8'h00);
    rd_msr = 1; msr_evt = 1; cyc();
    check("R9 set wins", iir, 8'h00);
    rd_msr = 1; cyc();
    check("R9 cleared", iir, 8'h01);

    fifo_en = 1; #1;
    check("R6 fifo bits", iir, 8'hC1);

    ier_wr = 1; ier_wdata = 4'h0; cyc();
    lsr_evt = 1; cyc();
    check("R12 disabled hidden irq", irq, 0);
    check("R12 disabled hidden iir", iir, 8'hC1);
    ier_wr = 1; ier_wdata = 4'h4; cyc();
    check("R12 enabled later", iir, 8'hC6);
    rd_lsr = 1; lsr_evt = 1; cyc();
    check("R7 set wins", iir, 8'hC6);
    rd_lsr = 1; cyc();
    check("R7 cleared", iir, 8'hC1);

    for (int i = 0; i < 3000; i++) begin
      lsr_evt = ($urandom % 9) == 0; rx_tmo_evt = ($urandom % 11) == 0;
      thr_xfer = ($urandom % 5) == 0; msr_evt = ($urandom % 7) == 0;
      rd_lsr = ($urandom % 4) == 0; rd_rbr = ($urandom % 4) == 0;
      rd_msr = ($urandom % 4) == 0; wr_thr = ($urandom % 6) == 0;
      rd_iir = ($urandom % 3) == 0; rx_level = ($urandom % 3) == 0;
      ier_wr = ($urandom % 20) == 0; ier_wdata = 4'($urandom);
      if ((i % 500) == 0) fifo_en = ~fifo_en;
      cyc();
    end
    repeat (2) cyc();
    report();
  end
endmodule